// File: doc/BRIEF.md
# Shift-First Restoring Integer Divider

This block divides an N-bit dividend by an N-bit divisor over several clock cycles. The caller supplies both operands together with a one-cycle start pulse. A mode input selects whether the operands are read as unsigned or as two's complement. While the block works, busy is high. When it finishes, done is high for one cycle, and the quotient and remainder appear on their own outputs. A zero divisor also raises a flag at completion.

A single working register holds both the partial remainder and the growing quotient. Its upper part carries the partial remainder and its lower N bits receive quotient bits, one per iteration. At start the dividend magnitude is loaded into the lower part and the whole register is shifted left once. Each iteration then tries to subtract the divisor from the upper part. A non-negative result is kept and a 1 is shifted in. A negative result leaves the upper part unchanged and a 0 is shifted in. After N iterations the upper part has been shifted one place too far, so the remainder is read from it shifted back right by one bit.

In signed mode the block divides magnitudes and then fixes the signs of the results. The quotient truncates toward zero and the remainder takes the sign of the dividend.

Top module: `restoring_divider`

## Requirements
- R1: After reset, busy, done and divZero are low, and quotient and remainder are zero.
- R2: In unsigned mode (signedMode = 0), quotient and remainder satisfy dividend = quotient * divisor + remainder with remainder < divisor. For example, 7 / 2 gives 3 remainder 1, and a dividend smaller than the divisor gives quotient 0 with the dividend as remainder.
- R3: A start sampled while busy is low is accepted. busy is high from the next cycle on, and done rises exactly N+1 clock edges after the accepting edge.
- R4: done is high for exactly one cycle per accepted start and is never high together with busy.
- R5: In signed mode (signedMode = 1) the quotient truncates toward zero and is negative when the operand signs differ. The remainder carries the sign of the dividend: -7 / 2 gives -3 remainder -1, and 7 / -2 gives -3 remainder 1.
- R6: In signed mode the most negative dividend divided by -1 gives the most negative value as quotient (the result wraps) and a remainder of 0.
- R7: A zero divisor completes with the normal timing. divZero is raised with done, the quotient is all ones and the remainder equals the dividend, in either mode. divZero falls again at the next completion with a non-zero divisor.
- R8: A start pulse that arrives while busy is high is ignored. The running division finishes with its own operands and its own timing.
- R9: quotient, remainder and divZero change only in the cycle in which done is high. They hold their values through a following division until it completes, including one started in the done cycle itself.
- R10: In unsigned mode the top operand bit counts as magnitude. With N = 8, 200 / 7 gives 28 remainder 4.
- R11: Operand and mode inputs are sampled only when a start is accepted. Changing them while busy does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (taken only when idle) |
| dividend | input | WIDTH | Dividend operand |
| divisor | input | WIDTH | Divisor operand |
| signedMode | input | 1 | 1: two's complement operands, 0: unsigned |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | WIDTH | Quotient of the last finished division |
| remainder | output | WIDTH | Remainder of the last finished division |
| divZero | output | 1 | Last finished division had a zero divisor |

## Verification
A completion and a new acceptance can fall in the same cycle. When done is high the block is idle again, so a start presented in that very cycle is taken at once. The bench provokes this by driving the next operands and start in the cycle in which done is observed high. It then checks that the new division still takes N+1 edges. It also checks at every sample in between that the quotient and remainder of the earlier division are held until the second done.

// File: rtl/div_pkg.sv
package div_pkg;

  // strobes from the sequencer to the datapath, one per phase
  typedef struct packed {
    logic load;    // capture operands and pre-shift
    logic step;    // one trial-subtract iteration
    logic finish;  // correct remainder, fix signs, publish
  } divCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } divState_t;

endpackage

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output divCtrl_t ctrl,
  output logic     busy,
  output logic     done
);

  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST_ITER = CW'(N - 1);

  divState_t      state;
  logic [CW-1:0]  iterCnt;

  always_comb begin
    ctrl.load   = (state == ST_IDLE) && start;
    ctrl.step   = (state == ST_RUN);
    ctrl.finish = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      iterCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_RUN;
            iterCnt <= '0;
          end
        end
        ST_RUN: begin
          iterCnt <= iterCnt + 1'b1;
          if (iterCnt == LAST_ITER) state <= ST_FIN;
        end
        ST_FIN: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/div_datapath.sv
module div_datapath
  import div_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  divCtrl_t     ctrl,
  input  logic [N-1:0] dividendIn,
  input  logic [N-1:0] divisorIn,
  input  logic         signedMode,
  output logic [N-1:0] quotient,
  output logic [N-1:0] remainder,
  output logic         divZero
);

  // upper part is N+1 bits wide: after the shift it may reach 2*divisor-1
  localparam int WW = 2 * N + 1;

  logic [WW-1:0] work;
  logic [N-1:0]  divMag;
  logic          negQuot;
  logic          negRem;
  logic          zeroDiv;

  // operand magnitudes at load
  logic          aNeg, bNeg;
  logic [N-1:0]  aMag, bMag;

  always_comb begin
    aNeg = signedMode & dividendIn[N-1];
    bNeg = signedMode & divisorIn[N-1];
    aMag = aNeg ? (~dividendIn + 1'b1) : dividendIn;
    bMag = bNeg ? (~divisorIn + 1'b1) : divisorIn;
  end

  // trial subtract, N+1 bits; the top bit flags a negative difference
  logic [N:0] trial;
  assign trial = work[WW-1:N] - {1'b0, divMag};

  // final correction and sign fix
  logic [N-1:0] remMag, quotMag;
  assign remMag  = work[WW-1:N+1];
  assign quotMag = work[N-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      work      <= '0;
      divMag    <= '0;
      negQuot   <= 1'b0;
      negRem    <= 1'b0;
      zeroDiv   <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      divZero   <= 1'b0;
    end else begin
      if (ctrl.load) begin
        work    <= {{N{1'b0}}, aMag, 1'b0};
        divMag  <= bMag;
        negQuot <= aNeg ^ bNeg;
        negRem  <= aNeg;
        zeroDiv <= (divisorIn == '0);
      end else if (ctrl.step) begin
        if (!trial[N]) work <= {trial[N-1:0], work[N-1:0], 1'b1};
        else           work <= {work[WW-2:0], 1'b0};
      end
      if (ctrl.finish) begin
        quotient  <= zeroDiv ? '1 : (negQuot ? (~quotMag + 1'b1) : quotMag);
        remainder <= negRem ? (~remMag + 1'b1) : remMag;
        divZero   <= zeroDiv;
      end
    end
  end

endmodule

// File: rtl/restoring_divider.sv
module restoring_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             signedMode,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             divZero
);

  divCtrl_t ctrl;

  div_ctrl #(.N(WIDTH)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .ctrl  (ctrl),
    .busy  (busy),
    .done  (done)
  );

  div_datapath #(.N(WIDTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .dividendIn (dividend),
    .divisorIn  (divisor),
    .signedMode (signedMode),
    .quotient   (quotient),
    .remainder  (remainder),
    .divZero    (divZero)
  );

endmodule

// File: rtl/div_checker.sv
module div_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] quotient,
  input logic [N-1:0] remainder,
  input logic         divZero
);

  // cycles since the last accepted start, saturating
  logic [15:0] sinceStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceStart <= '0;
    else if (start && !busy) sinceStart <= '0;
    else if (sinceStart != 16'hFFFF) sinceStart <= sinceStart + 1'b1;
  end

  // R4
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R4
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R3
  a_r3_latency: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sinceStart == 16'(N + 1)));

  // R9
  a_r9_quot_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(quotient) |-> done);

  // R9
  a_r9_rem_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(remainder) |-> done);

  // R7
  a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divZero) |-> done);

endmodule

bind restoring_divider div_checker #(.N(WIDTH)) i_div_checker (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .quotient  (quotient),
  .remainder (remainder),
  .divZero   (divZero)
);

// File: tb/test_restoring_divider.sv
module test_restoring_divider;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] dividend = '0;
  logic [N-1:0] divisor = '0;
  logic         signedMode = 1'b0;
  logic         busy, done, divZero;
  logic [N-1:0] quotient, remainder;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  restoring_divider #(.WIDTH(N)) i_restoring_divider (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .dividend   (dividend),
    .divisor    (divisor),
    .signedMode (signedMode),
    .busy       (busy),
    .done       (done),
    .quotient   (quotient),
    .remainder  (remainder),
    .divZero    (divZero)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected results computed from the requirements
  task automatic expected(input logic [N-1:0] a, input logic [N-1:0] b, input bit sgn,
                          output logic [N-1:0] q, output logic [N-1:0] r, output bit z);
    longint sa, sb;
    z = (b == '0);
    if (z) begin
      q = '1;
      r = a;
    end else if (sgn) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      q = N'(sa / sb);
      r = N'(sa % sb);
    end else begin
      q = a / b;
      r = a % b;
    end
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic launch(input logic [N-1:0] a, input logic [N-1:0] b, input bit sgn);
    dividend   = a;
    divisor    = b;
    signedMode = sgn;
    start      = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output int lat, output bit busyOk);
    lat = 0;
    busyOk = 1'b1;
    while (!done && lat < 200) begin
      if (!busy) busyOk = 1'b0;
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic checkRes(input logic [N-1:0] a, input logic [N-1:0] b, input bit sgn,
                          input string req);
    logic [N-1:0] eq, er;
    bit ez;
    expected(a, b, sgn, eq, er, ez);
    chk(quotient == eq, req, "quotient", quotient, eq);
    chk(remainder == er, req, "remainder", remainder, er);
    chk(divZero == ez, req, "divZero", divZero, ez);
  endtask

  task automatic runOne(input logic [N-1:0] a, input logic [N-1:0] b, input bit sgn,
                        input string req);
    int lat;
    bit busyOk;
    launch(a, b, sgn);
    waitDone(lat, busyOk);
    chk(lat == N + 1, "R3", "latency", lat, N + 1);
    chk(busyOk, "R3", "busy while running", busyOk, 1);
    chk(!busy, "R4", "busy with done", busy, 0);
    checkRes(a, b, sgn, req);
    @(negedge clk);
    chk(!done, "R4", "done width", done, 0);
  endtask

  task automatic testReset();
    chk(!busy, "R1", "busy", busy, 0);
    chk(!done, "R1", "done", done, 0);
    chk(!divZero, "R1", "divZero", divZero, 0);
    chk(quotient == '0, "R1", "quotient", quotient, 0);
    chk(remainder == '0, "R1", "remainder", remainder, 0);
  endtask

  task automatic testUnsigned();
    runOne(8'd7, 8'd2, 1'b0, "R2");
    runOne(8'd5, 8'd9, 1'b0, "R2");
    runOne(8'd255, 8'd1, 1'b0, "R2");
    runOne(8'd255, 8'd255, 1'b0, "R2");
    runOne(8'd200, 8'd7, 1'b0, "R10");
    runOne(8'd250, 8'd130, 1'b0, "R10");
  endtask

  task automatic testSigned();
    runOne(-8'sd7, 8'sd2, 1'b1, "R5");
    runOne(8'sd7, -8'sd2, 1'b1, "R5");
    runOne(-8'sd7, -8'sd2, 1'b1, "R5");
    runOne(8'sd100, 8'sd9, 1'b1, "R5");
    runOne(8'h80, 8'hFF, 1'b1, "R6");
    runOne(8'h80, 8'sd1, 1'b1, "R6");
  endtask

  task automatic testZero();
    runOne(8'd77, 8'd0, 1'b0, "R7");
    runOne(-8'sd5, 8'd0, 1'b1, "R7");
    runOne(8'd9, 8'd3, 1'b0, "R7");
  endtask

  // R8 and R11: start and operand changes during a run have no effect
  task automatic testBusyStart();
    int lat;
    bit busyOk;
    launch(8'd100, 8'd7, 1'b0);
    @(negedge clk);
    @(negedge clk);
    dividend   = 8'd1;
    divisor    = 8'd1;
    signedMode = 1'b1;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(lat, busyOk);
    chk(lat == N - 2, "R8", "latency with extra start", lat + 3, N + 1);
    checkRes(8'd100, 8'd7, 1'b0, "R11");
    @(negedge clk);
    chk(!done, "R8", "second done", done, 0);
    chk(!busy, "R8", "restarted", busy, 0);
  endtask

  // R9: start accepted in the done cycle, old results held until next done
  task automatic testBackToBack();
    int lat;
    bit busyOk;
    bit held;
    launch(8'd50, 8'd6, 1'b0);
    waitDone(lat, busyOk);
    checkRes(8'd50, 8'd6, 1'b0, "R9");
    launch(8'd99, 8'd10, 1'b0);
    lat = 0;
    held = 1'b1;
    while (!done && lat < 200) begin
      if (quotient != 8'd8 || remainder != 8'd2) held = 1'b0;
      @(negedge clk);
      lat++;
    end
    chk(held, "R9", "results held during next run", held, 1);
    chk(lat == N + 1, "R9", "latency of start in done cycle", lat, N + 1);
    checkRes(8'd99, 8'd10, 1'b0, "R9");
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUnsigned();
    testSigned();
    testZero();
    testBusyStart();
    testBackToBack();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule